// File: doc/BRIEF.md
# Associative Address Translation Lookup with Protection Check

This block turns a 32-bit virtual address into a physical address in a single combinational pass. The access is one of three kinds: a data read, a data write or an instruction fetch. Fixed address windows are decided first. Some windows bypass translation and have their top three bits stripped. One window passes through unchanged. In user mode, some windows raise an address error. Any other address, when translation is on, is compared at the same time against every entry of a fully associative table. Each entry carries its own page size (1 KB, 4 KB, 64 KB or 1 MB), an 8-bit address-space tag and a shared flag.

The result is a physical address, a set of read/write/execute grants, the index of the matching entry and a 12-bit fault code. Code zero, together with the `xlateOk` flag, means success. Faults cover several cases: a miss, more than one matching entry, a user access to a supervisor-only page, a write to a read-only page, and a first write to a clean page. The entry contents arrive on flat port vectors from storage that lies outside this block. Loading that storage is the job of the surrounding logic.

Top module: `tlbl_top`

## Requirements
- R1: In privileged mode, addresses 0x80000000 to 0xBFFFFFFF skip the table. The result is the address with bits [31:29] cleared, fault code 0 and all three grants set.
- R2: In privileged mode, addresses at or above 0xE0000000 skip the table. The result is the unchanged address, fault code 0 and all three grants set.
- R3: In user mode, an address in either bypass window that lies outside 0xE0000000 to 0xE3FFFFFF faults with code 0x0E0 for reads and fetches and 0x100 for writes. Addresses inside 0xE0000000 to 0xE3FFFFFF pass through unchanged.
- R4: With `xlateEn` = 0, every address outside the bypass windows maps to itself with bits [31:29] cleared, and all grants are set.
- R5: With translation on, an entry's 22-bit page tag (address bits [31:10]) is aligned down to its page size. The size code is 00 = 1 KB, 01 = 4 KB, 10 = 64 KB and 11 = 1 MB. The physical address is then the size-aligned frame number joined with the in-page offset of the address.
- R6: An entry whose valid bit is set matches only if one of three things holds: its tag equals `curAsid`, its shared bit is set, or tag checking is off. Tag checking is off only when both `singleVirt` and `privMode` are 1.
- R7: When no entry matches, the code is 0x060 for a write and 0x040 for a read or fetch. Access kinds are encoded as 00 = read, 01 = write, 10 = fetch; 11 behaves as a read.
- R8: Two or more matching entries give code 0x140 with `hitValid` = 0.
- R9: In user mode, a single hit on an entry whose protection bit [1] is 0 gives code 0x0A0 for reads and fetches and 0x0C0 for writes.
- R10: A write that passes the R9 check still faults in two cases. If protection bit [0] is 0 the code is 0x0C0. Otherwise, if the dirty bit is 0, the code is 0x080.
- R11: On success, `xlateOk` = 1 and the code is 0. A translated success always grants read. It grants write only when protection bit [0] and the dirty bit are both 1, and grants execute only for a fetch. On any fault, `xlateOk` = 0 and the physical address and all grants are 0.
- R12: On exactly one match in the translated path, `hitValid` = 1 and `hitIndex` names that entry, even if a protection fault follows. Entries whose valid bit is 0 never match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| vaddr | input | 32 | Virtual address |
| accKind | input | 2 | Access kind: 00 read, 01 write, 10 fetch |
| privMode | input | 1 | 1 = privileged, 0 = user |
| xlateEn | input | 1 | Translation enable |
| singleVirt | input | 1 | Single virtual space mode; with privMode disables tag checking |
| curAsid | input | 8 | Current address-space tag |
| entValid | input | NUM_ENTRIES | Per-entry valid bits |
| entShared | input | NUM_ENTRIES | Per-entry shared bits |
| entAsid | input | 8*NUM_ENTRIES | Per-entry address-space tags |
| entVpn | input | 22*NUM_ENTRIES | Per-entry virtual page tags, address bits [31:10] |
| entPpn | input | 22*NUM_ENTRIES | Per-entry physical frame numbers, address bits [31:10] |
| entSize | input | 2*NUM_ENTRIES | Per-entry page size code |
| entProt | input | 2*NUM_ENTRIES | Per-entry protection: [1] user access, [0] writable |
| entDirty | input | NUM_ENTRIES | Per-entry dirty bits |
| physAddr | output | 32 | Physical address, 0 on fault |
| permRead | output | 1 | Read granted |
| permWrite | output | 1 | Write granted |
| permExec | output | 1 | Execute granted |
| hitValid | output | 1 | Exactly one matching entry on the translated path |
| hitIndex | output | IDX_W | Index of the matching entry |
| faultCode | output | 12 | Fault code, 0 on success |
| xlateOk | output | 1 | Lookup succeeded |

## Verification
The bench builds the block with six entries. That count is not a power of two, so the index is three bits wide and codes 6 and 7 are never legal. Entry 5 is the top slot the encoder must reach. Six entries also leave room to set one entry of each page size alongside two overlapping entries and an invalid decoy. This makes multi-hit, size-alignment and valid-gating cases possible in a single table image.

// File: rtl/tlbl_pkg.sv
package tlbl_pkg;

  localparam int VA_W     = 32;
  localparam int PAGE_LSB = 10;
  localparam int VPN_W    = VA_W - PAGE_LSB;
  localparam int ASID_W   = 8;
  localparam int FC_W     = 12;

  typedef enum logic [1:0] {
    ACC_READ  = 2'b00,
    ACC_WRITE = 2'b01,
    ACC_FETCH = 2'b10,
    ACC_RSVD  = 2'b11
  } acc_kind_e;

  localparam logic [FC_W-1:0] FC_NONE       = 12'h000;
  localparam logic [FC_W-1:0] FC_MISS_RD    = 12'h040;
  localparam logic [FC_W-1:0] FC_MISS_WR    = 12'h060;
  localparam logic [FC_W-1:0] FC_FIRST_WR   = 12'h080;
  localparam logic [FC_W-1:0] FC_PROT_RD    = 12'h0A0;
  localparam logic [FC_W-1:0] FC_PROT_WR    = 12'h0C0;
  localparam logic [FC_W-1:0] FC_ADDR_RD    = 12'h0E0;
  localparam logic [FC_W-1:0] FC_ADDR_WR    = 12'h100;
  localparam logic [FC_W-1:0] FC_MULTI      = 12'h140;

  // Strobes from the control half to the datapath half: output address source
  typedef struct packed {
    logic useTlb;
    logic maskTop;
    logic passRaw;
  } dp_strobe_t;

  // Mask of page-tag bits that form the page base for a given size code
  function automatic logic [VPN_W-1:0] pageBaseMask(input logic [1:0] sizeCode);
    int shamt;
    case (sizeCode)
      2'b00:   shamt = 0;
      2'b01:   shamt = 2;
      2'b10:   shamt = 6;
      default: shamt = 10;
    endcase
    return {VPN_W{1'b1}} << shamt;
  endfunction

endpackage

// File: rtl/tlbl_entry_cmp.sv
module tlbl_entry_cmp
  import tlbl_pkg::*;
(
  input  logic [VPN_W-1:0]  vaHigh,
  input  logic [ASID_W-1:0] curAsid,
  input  logic              asidChk,
  input  logic              entValid,
  input  logic              entShared,
  input  logic [ASID_W-1:0] entAsid,
  input  logic [VPN_W-1:0]  entVpn,
  input  logic [1:0]        entSize,
  output logic              isHit,
  output logic [VPN_W-1:0]  baseMask
);

  logic asidOk;
  logic tagEq;

  assign baseMask = pageBaseMask(entSize);
  assign asidOk   = entShared | ~asidChk | (entAsid == curAsid);
  assign tagEq    = ((vaHigh ^ entVpn) & baseMask) == '0;
  assign isHit    = entValid & asidOk & tagEq;

endmodule

// File: rtl/tlbl_xlate_dp.sv
module tlbl_xlate_dp
  import tlbl_pkg::*;
#(
  parameter int NUM_ENTRIES = 4,
  localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1,
  localparam int CNT_W = $clog2(NUM_ENTRIES + 1)
)(
  input  logic [VA_W-1:0]               vaddr,
  input  logic [ASID_W-1:0]             curAsid,
  input  logic                          asidChk,
  input  logic [NUM_ENTRIES-1:0]        entValid,
  input  logic [NUM_ENTRIES-1:0]        entShared,
  input  logic [NUM_ENTRIES*ASID_W-1:0] entAsid,
  input  logic [NUM_ENTRIES*VPN_W-1:0]  entVpn,
  input  logic [NUM_ENTRIES*VPN_W-1:0]  entPpn,
  input  logic [NUM_ENTRIES*2-1:0]      entSize,
  input  logic [NUM_ENTRIES*2-1:0]      entProt,
  input  logic [NUM_ENTRIES-1:0]        entDirty,
  input  dp_strobe_t                    strobe,
  output logic                          hitAny,
  output logic                          hitMulti,
  output logic [IDX_W-1:0]              selIdx,
  output logic [1:0]                    selProt,
  output logic                          selDirty,
  output logic [VA_W-1:0]               physAddr
);

  logic [NUM_ENTRIES-1:0] hitVec;
  logic [VPN_W-1:0]       maskArr [NUM_ENTRIES];
  logic [CNT_W-1:0]       hitCnt;
  logic [VPN_W-1:0]       selPpn;
  logic [VPN_W-1:0]       selMask;
  logic [VPN_W-1:0]       tlbFrame;

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_cmp
    tlbl_entry_cmp u_cmp (
      .vaHigh   (vaddr[VA_W-1:PAGE_LSB]),
      .curAsid  (curAsid),
      .asidChk  (asidChk),
      .entValid (entValid[g]),
      .entShared(entShared[g]),
      .entAsid  (entAsid[g*ASID_W +: ASID_W]),
      .entVpn   (entVpn[g*VPN_W +: VPN_W]),
      .entSize  (entSize[g*2 +: 2]),
      .isHit    (hitVec[g]),
      .baseMask (maskArr[g])
    );
  end

  // Count of hits and lowest hitting index
  always_comb begin
    hitCnt = '0;
    selIdx = '0;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      hitCnt = hitCnt + CNT_W'(hitVec[i]);
    end
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (hitVec[i]) selIdx = IDX_W'(i);
    end
  end

  assign hitAny   = |hitVec;
  assign hitMulti = hitCnt > CNT_W'(1);

  // OR-mux of the hitting entry's fields (exact when one entry hits)
  always_comb begin
    selPpn   = '0;
    selMask  = '0;
    selProt  = '0;
    selDirty = 1'b0;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      if (hitVec[i]) begin
        selPpn   = selPpn   | entPpn[i*VPN_W +: VPN_W];
        selMask  = selMask  | maskArr[i];
        selProt  = selProt  | entProt[i*2 +: 2];
        selDirty = selDirty | entDirty[i];
      end
    end
  end

  assign tlbFrame = (selPpn & selMask) | (vaddr[VA_W-1:PAGE_LSB] & ~selMask);

  always_comb begin
    if (strobe.useTlb)       physAddr = {tlbFrame, vaddr[PAGE_LSB-1:0]};
    else if (strobe.maskTop) physAddr = {3'b000, vaddr[VA_W-4:0]};
    else if (strobe.passRaw) physAddr = vaddr;
    else                     physAddr = '0;
  end

endmodule

// File: rtl/tlbl_fault_ctrl.sv
module tlbl_fault_ctrl
  import tlbl_pkg::*;
(
  input  logic [VA_W-1:0] vaddr,
  input  logic [1:0]      accKind,
  input  logic            privMode,
  input  logic            xlateEn,
  input  logic            singleVirt,
  input  logic            hitAny,
  input  logic            hitMulti,
  input  logic [1:0]      selProt,
  input  logic            selDirty,
  output logic            asidChk,
  output dp_strobe_t      strobe,
  output logic [FC_W-1:0] faultCode,
  output logic            xlateOk,
  output logic            permRead,
  output logic            permWrite,
  output logic            permExec,
  output logic            hitValid
);

  logic inLowWin;
  logic inHighWin;
  logic inUserHole;
  logic isWrite;
  logic isFetch;

  assign inLowWin   = vaddr[31:30] == 2'b10;
  assign inHighWin  = vaddr[31:29] == 3'b111;
  assign inUserHole = vaddr[31:26] == 6'b111000;
  assign isWrite    = accKind == ACC_WRITE;
  assign isFetch    = accKind == ACC_FETCH;
  assign asidChk    = ~singleVirt | ~privMode;

  always_comb begin
    strobe    = '0;
    faultCode = FC_NONE;
    permRead  = 1'b0;
    permWrite = 1'b0;
    permExec  = 1'b0;
    hitValid  = 1'b0;
    if (inLowWin || inHighWin) begin
      if (!privMode && !(inHighWin && inUserHole)) begin
        faultCode = isWrite ? FC_ADDR_WR : FC_ADDR_RD;
      end else begin
        strobe.maskTop = inLowWin;
        strobe.passRaw = inHighWin;
        permRead  = 1'b1;
        permWrite = 1'b1;
        permExec  = 1'b1;
      end
    end else if (!xlateEn) begin
      strobe.maskTop = 1'b1;
      permRead  = 1'b1;
      permWrite = 1'b1;
      permExec  = 1'b1;
    end else if (!hitAny) begin
      faultCode = isWrite ? FC_MISS_WR : FC_MISS_RD;
    end else if (hitMulti) begin
      faultCode = FC_MULTI;
    end else begin
      hitValid = 1'b1;
      if (!privMode && !selProt[1]) begin
        faultCode = isWrite ? FC_PROT_WR : FC_PROT_RD;
      end else if (isWrite && !selProt[0]) begin
        faultCode = FC_PROT_WR;
      end else if (isWrite && !selDirty) begin
        faultCode = FC_FIRST_WR;
      end else begin
        strobe.useTlb = 1'b1;
        permRead  = 1'b1;
        permWrite = selProt[0] & selDirty;
        permExec  = isFetch;
      end
    end
  end

  assign xlateOk = faultCode == FC_NONE;

endmodule

// File: rtl/tlbl_top.sv
module tlbl_top
  import tlbl_pkg::*;
#(
  parameter int NUM_ENTRIES = 4,
  localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
)(
  input  logic [31:0]                vaddr,
  input  logic [1:0]                 accKind,
  input  logic                       privMode,
  input  logic                       xlateEn,
  input  logic                       singleVirt,
  input  logic [7:0]                 curAsid,
  input  logic [NUM_ENTRIES-1:0]     entValid,
  input  logic [NUM_ENTRIES-1:0]     entShared,
  input  logic [NUM_ENTRIES*8-1:0]   entAsid,
  input  logic [NUM_ENTRIES*22-1:0]  entVpn,
  input  logic [NUM_ENTRIES*22-1:0]  entPpn,
  input  logic [NUM_ENTRIES*2-1:0]   entSize,
  input  logic [NUM_ENTRIES*2-1:0]   entProt,
  input  logic [NUM_ENTRIES-1:0]     entDirty,
  output logic [31:0]                physAddr,
  output logic                       permRead,
  output logic                       permWrite,
  output logic                       permExec,
  output logic                       hitValid,
  output logic [IDX_W-1:0]           hitIndex,
  output logic [11:0]                faultCode,
  output logic                       xlateOk
);

  dp_strobe_t dpStrobe;
  logic       asidChk;
  logic       hitAny;
  logic       hitMulti;
  logic [1:0] selProt;
  logic       selDirty;

  tlbl_xlate_dp #(.NUM_ENTRIES(NUM_ENTRIES)) u_dp (
    .vaddr    (vaddr),
    .curAsid  (curAsid),
    .asidChk  (asidChk),
    .entValid (entValid),
    .entShared(entShared),
    .entAsid  (entAsid),
    .entVpn   (entVpn),
    .entPpn   (entPpn),
    .entSize  (entSize),
    .entProt  (entProt),
    .entDirty (entDirty),
    .strobe   (dpStrobe),
    .hitAny   (hitAny),
    .hitMulti (hitMulti),
    .selIdx   (hitIndex),
    .selProt  (selProt),
    .selDirty (selDirty),
    .physAddr (physAddr)
  );

  tlbl_fault_ctrl u_ctrl (
    .vaddr     (vaddr),
    .accKind   (accKind),
    .privMode  (privMode),
    .xlateEn   (xlateEn),
    .singleVirt(singleVirt),
    .hitAny    (hitAny),
    .hitMulti  (hitMulti),
    .selProt   (selProt),
    .selDirty  (selDirty),
    .asidChk   (asidChk),
    .strobe    (dpStrobe),
    .faultCode (faultCode),
    .xlateOk   (xlateOk),
    .permRead  (permRead),
    .permWrite (permWrite),
    .permExec  (permExec),
    .hitValid  (hitValid)
  );

endmodule

// File: rtl/tlbl_checker.sv
module tlbl_checker (
  input logic [31:0] vaddr,
  input logic [1:0]  accKind,
  input logic        privMode,
  input logic [31:0] physAddr,
  input logic        permRead,
  input logic        permWrite,
  input logic        permExec,
  input logic        hitValid,
  input logic [11:0] faultCode,
  input logic        xlateOk
);

  always_comb begin
    // R11: success flag agrees with the code
    assert_ok_flag_R11: assert (xlateOk == (faultCode == 12'h000));
    // R11: a fault leaves no address and no grants
    if (faultCode != 12'h000) begin
      assert_fault_quiet_R11: assert (physAddr == 32'h0 && !permRead && !permWrite && !permExec);
    end
    // R8: multi-hit never reports a single hit
    if (faultCode == 12'h140) begin
      assert_multi_nohit_R8: assert (!hitValid);
    end
    // R7: a reported hit is never a miss code
    if (hitValid) begin
      assert_hit_not_miss_R7: assert (faultCode != 12'h040 && faultCode != 12'h060);
    end
    // R1: privileged low window strips the top three bits
    if (privMode && vaddr[31:30] == 2'b10) begin
      assert_low_window_R1: assert (xlateOk && physAddr == {3'b000, vaddr[28:0]});
    end
    // R3: user access to a forbidden window is an address error
    if (!privMode && vaddr[31] && vaddr[31:29] != 3'b110 && vaddr[31:26] != 6'b111000) begin
      assert_user_window_R3: assert (faultCode == (accKind == 2'b01 ? 12'h100 : 12'h0E0));
    end
    // R10: a successful translated write always carries write permission
    if (xlateOk && hitValid && accKind == 2'b01) begin
      assert_write_grant_R10: assert (permWrite);
    end
  end

endmodule

bind tlbl_top tlbl_checker u_chk (
  .vaddr    (vaddr),
  .accKind  (accKind),
  .privMode (privMode),
  .physAddr (physAddr),
  .permRead (permRead),
  .permWrite(permWrite),
  .permExec (permExec),
  .hitValid (hitValid),
  .faultCode(faultCode),
  .xlateOk  (xlateOk)
);

// File: tb/sim_tlbl_top.sv
module sim_tlbl_top;

  localparam int N  = 6;
  localparam int IW = 3;

  logic clk = 1'b0;
  logic rst;
  always #5 clk = ~clk;

  logic [31:0]   vaddr;
  logic [1:0]    accKind;
  logic          privMode, xlateEn, singleVirt;
  logic [7:0]    curAsid;
  logic [N-1:0]  entValid, entShared, entDirty;
  logic [N*8-1:0]  entAsid;
  logic [N*22-1:0] entVpn, entPpn;
  logic [N*2-1:0]  entSize, entProt;
  logic [31:0]   physAddr;
  logic          permRead, permWrite, permExec, hitValid, xlateOk;
  logic [IW-1:0] hitIndex;
  logic [11:0]   faultCode;

  bit        ev [N];
  bit        esh[N];
  bit        ed [N];
  bit [7:0]  eas[N];
  bit [21:0] evp[N];
  bit [21:0] epp[N];
  bit [1:0]  esz[N];
  bit [1:0]  epr[N];

  always_comb begin
    for (int i = 0; i < N; i++) begin
      entValid[i]         = ev[i];
      entShared[i]        = esh[i];
      entDirty[i]         = ed[i];
      entAsid[i*8 +: 8]   = eas[i];
      entVpn[i*22 +: 22]  = evp[i];
      entPpn[i*22 +: 22]  = epp[i];
      entSize[i*2 +: 2]   = esz[i];
      entProt[i*2 +: 2]   = epr[i];
    end
  end

  tlbl_top #(.NUM_ENTRIES(N)) u0 (
    .vaddr(vaddr), .accKind(accKind), .privMode(privMode), .xlateEn(xlateEn),
    .singleVirt(singleVirt), .curAsid(curAsid),
    .entValid(entValid), .entShared(entShared), .entAsid(entAsid), .entVpn(entVpn),
    .entPpn(entPpn), .entSize(entSize), .entProt(entProt), .entDirty(entDirty),
    .physAddr(physAddr), .permRead(permRead), .permWrite(permWrite), .permExec(permExec),
    .hitValid(hitValid), .hitIndex(hitIndex), .faultCode(faultCode), .xlateOk(xlateOk)
  );

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  longint unsigned expPhys;
  int  expCode, expIdx;
  bit  expR, expW, expX, expHv;

  // Behavioural reference from the requirements
  task automatic model();
    longint unsigned a, sz, base;
    bit wr, chk;
    int hits;
    a = vaddr;
    wr = (accKind == 2'b01);
    chk = !singleVirt || !privMode;
    expPhys = 0; expCode = 0; expR = 0; expW = 0; expX = 0; expHv = 0; expIdx = -1;
    if ((a >= 64'h8000_0000 && a < 64'hC000_0000) || a >= 64'hE000_0000) begin
      if (!privMode && (a < 64'hE000_0000 || a >= 64'hE400_0000)) begin
        expCode = wr ? 'h100 : 'h0E0;
      end else begin
        expPhys = (a < 64'hC000_0000) ? (a & 64'h1FFF_FFFF) : a;
        expR = 1; expW = 1; expX = 1;
      end
    end else if (!xlateEn) begin
      expPhys = a & 64'h1FFF_FFFF;
      expR = 1; expW = 1; expX = 1;
    end else begin
      hits = 0;
      for (int i = 0; i < N; i++) begin
        sz = (esz[i] == 0) ? 1024 : (esz[i] == 1) ? 4096 : (esz[i] == 2) ? 65536 : 1048576;
        base = (longint'(evp[i]) * 1024) & ~(sz - 1);
        if (ev[i] && (esh[i] || !chk || eas[i] == curAsid) && a >= base && a < base + sz) begin
          hits++;
          expIdx = i;
        end
      end
      if (hits == 0) expCode = wr ? 'h060 : 'h040;
      else if (hits > 1) expCode = 'h140;
      else begin
        expHv = 1;
        if (!privMode && !epr[expIdx][1]) expCode = wr ? 'h0C0 : 'h0A0;
        else if (wr && !epr[expIdx][0]) expCode = 'h0C0;
        else if (wr && !ed[expIdx]) expCode = 'h080;
        else begin
          sz = (esz[expIdx] == 0) ? 1024 : (esz[expIdx] == 1) ? 4096 :
               (esz[expIdx] == 2) ? 65536 : 1048576;
          expPhys = ((longint'(epp[expIdx]) * 1024) & ~(sz - 1)) | (a & (sz - 1));
          expR = 1; expW = epr[expIdx][0] && ed[expIdx]; expX = (accKind == 2'b10);
        end
      end
    end
  endtask

  task automatic chk(input string tag);
    bit bad;
    @(negedge clk);
    model();
    checks++;
    bad = (physAddr != expPhys[31:0]) || (faultCode != 12'(expCode)) ||
          (xlateOk != (expCode == 0)) || (permRead != expR) || (permWrite != expW) ||
          (permExec != expX) || (hitValid != expHv) || (expHv && hitIndex != IW'(expIdx));
    if (bad) begin
      errors++;
      $display("FAIL %s va=%h: phys=%h code=%h ok=%b rwx=%b%b%b hv=%b idx=%0d expected phys=%h code=%h rwx=%b%b%b hv=%b idx=%0d",
               tag, vaddr, physAddr, faultCode, xlateOk, permRead, permWrite, permExec, hitValid,
               hitIndex, expPhys[31:0], expCode[11:0], expR, expW, expX, expHv, expIdx);
    end
  endtask

  task automatic drive(input logic [31:0] a, input logic [1:0] k, input bit p,
                       input bit x, input bit s, input logic [7:0] id);
    @(posedge clk);
    #1;
    vaddr = a; accKind = k; privMode = p; xlateEn = x; singleVirt = s; curAsid = id;
  endtask

  task automatic setEnt(input int i, input bit v, input bit sh, input logic [7:0] id,
                        input logic [31:0] va, input logic [31:0] pa, input logic [1:0] sz,
                        input logic [1:0] pr, input bit d);
    ev[i] = v; esh[i] = sh; eas[i] = id; evp[i] = va[31:10]; epp[i] = pa[31:10];
    esz[i] = sz; epr[i] = pr; ed[i] = d;
  endtask

  task automatic clearAll();
    for (int i = 0; i < N; i++) setEnt(i, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst = 1;
    clearAll();
    vaddr = 0; accKind = 0; privMode = 0; xlateEn = 0; singleVirt = 0; curAsid = 0;
    chk("R4");   // reset-time idle state: untranslated address 0
    repeat (2) @(posedge clk);
    rst = 0;

    // Window rules
    drive(32'h8123_4567, 2'b00, 1, 1, 0, 0); chk("R1");
    drive(32'hA765_4321, 2'b01, 1, 0, 0, 0); chk("R1");
    drive(32'hE800_0010, 2'b10, 1, 1, 0, 0); chk("R2");
    drive(32'hFFFF_FFFC, 2'b00, 1, 0, 0, 0); chk("R2");
    drive(32'h8000_0000, 2'b00, 0, 1, 0, 0); chk("R3");
    drive(32'hBFFF_FFFF, 2'b01, 0, 1, 0, 0); chk("R3");
    drive(32'hE400_0000, 2'b10, 0, 1, 0, 0); chk("R3");
    drive(32'hE3FF_FFF0, 2'b01, 0, 1, 0, 0); chk("R3");
    drive(32'h7FFF_1234, 2'b00, 0, 0, 0, 0); chk("R4");
    drive(32'hC000_4444, 2'b01, 1, 0, 0, 0); chk("R4");

    // Page sizes and frame forming
    setEnt(0, 1, 0, 8'h05, 32'h0040_0000, 32'h0008_0000, 2'b01, 2'b11, 1);
    setEnt(1, 1, 0, 8'h05, 32'h0100_0400, 32'h0330_0C00, 2'b00, 2'b11, 1);
    setEnt(2, 1, 0, 8'h05, 32'h0200_1C00, 32'h0A00_FC00, 2'b10, 2'b11, 1);
    setEnt(3, 1, 0, 8'h05, 32'h3050_0000, 32'h1234_5678, 2'b11, 2'b11, 1);
    drive(32'h0040_0ABC, 2'b00, 1, 1, 0, 8'h05); chk("R5");
    drive(32'h0100_04FF, 2'b10, 1, 1, 0, 8'h05); chk("R5");
    drive(32'h0100_0800, 2'b00, 1, 1, 0, 8'h05); chk("R5");
    drive(32'h0200_FFFF, 2'b01, 1, 1, 0, 8'h05); chk("R5");
    drive(32'h30FF_FFFF, 2'b00, 0, 1, 0, 8'h05); chk("R5");

    // Address-space tag rules
    drive(32'h0040_0010, 2'b00, 0, 1, 0, 8'h06); chk("R6");
    drive(32'h0040_0010, 2'b00, 1, 1, 1, 8'h06); chk("R6");
    drive(32'h0040_0010, 2'b00, 0, 1, 1, 8'h06); chk("R6");
    esh[0] = 1;
    drive(32'h0040_0010, 2'b00, 0, 1, 0, 8'h06); chk("R6");
    esh[0] = 0;

    // Misses
    drive(32'h5000_0000, 2'b01, 1, 1, 0, 8'h05); chk("R7");
    drive(32'h5000_0000, 2'b10, 1, 1, 0, 8'h05); chk("R7");
    drive(32'h5000_0000, 2'b11, 1, 1, 0, 8'h05); chk("R7");

    // Multi-hit: entry 4 overlaps entry 0
    setEnt(4, 1, 1, 8'h00, 32'h0040_0800, 32'h0009_0000, 2'b00, 2'b11, 1);
    drive(32'h0040_0900, 2'b00, 1, 1, 0, 8'h05); chk("R8");
    drive(32'h0040_0100, 2'b00, 1, 1, 0, 8'h05); chk("R8");
    ev[4] = 0;

    // Invalid decoy and top index
    setEnt(5, 1, 0, 8'h05, 32'h6000_0000, 32'h0100_0000, 2'b01, 2'b10, 0);
    setEnt(4, 0, 1, 8'h05, 32'h6000_0000, 32'h0F00_0000, 2'b01, 2'b11, 1);
    drive(32'h6000_0123, 2'b00, 1, 1, 0, 8'h05); chk("R12");

    // User protection
    drive(32'h6000_0123, 2'b00, 0, 1, 0, 8'h05); chk("R12");
    epr[5] = 2'b00;
    drive(32'h6000_0123, 2'b00, 0, 1, 0, 8'h05); chk("R9");
    drive(32'h6000_0123, 2'b01, 0, 1, 0, 8'h05); chk("R9");
    drive(32'h6000_0123, 2'b10, 0, 1, 0, 8'h05); chk("R9");

    // Write checks
    drive(32'h6000_0123, 2'b01, 1, 1, 0, 8'h05); chk("R10");
    epr[5] = 2'b11;
    drive(32'h6000_0123, 2'b01, 1, 1, 0, 8'h05); chk("R10");
    epr[5] = 2'b01;
    drive(32'h6000_0123, 2'b01, 0, 1, 0, 8'h05); chk("R10");
    epr[5] = 2'b11; ed[5] = 1;
    drive(32'h6000_0123, 2'b01, 0, 1, 0, 8'h05); chk("R11");
    drive(32'h6000_0123, 2'b10, 0, 1, 0, 8'h05); chk("R11");

    // Random sweep
    for (int n = 0; n < 400; n++) begin
      for (int i = 0; i < N; i++) begin
        if (n % 40 == 0)
          setEnt(i, 1'($urandom), 1'($urandom % 4 == 0), 8'($urandom % 3),
                 {3'($urandom % 3), 29'($urandom)} & 32'h7FFF_FFFF,
                 32'($urandom), 2'($urandom), 2'($urandom), 1'($urandom));
      end
      begin
        int k = $urandom % N;
        logic [31:0] a;
        a = ($urandom % 2 == 0) ? ({evp[k], 10'b0} + 32'($urandom % 4096)) : 32'($urandom);
        drive(a, 2'($urandom), 1'($urandom), ($urandom % 8) != 0, 1'($urandom), 8'($urandom % 3));
        chk("R11");
      end
    end

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule